// File: doc/BRIEF.md
# Masked Write and Block-Write Unit

This block models the write side of a four-plane video memory. Each access opens a row with a row-strobe pulse and then issues one or more column-strobe pulses against that row. The levels of the active-low write enable and of a function-select input are sampled at each strobe, together with the shared address bus and the four-bit data bus. From these samples the block picks one of several actions. It can write one column plainly or under a per-plane mask. The mask can come from the data bus for one row cycle only, or it can come from a stored mask that persists. A block write fans a colour register out to up to four neighbouring columns in a single cycle. Two configuration cycles load the colour register and the stored mask.

The array is kept as one single-bit memory per column lane and bit plane. A block write therefore becomes up to sixteen independently gated bit writes in one clock. A read port returns any stored word two clocks after its address is presented, so the array can be inspected.

Top module: `vram_write_unit`

## Requirements
- R1: After reset, rd_data is 0, the colour register and the stored mask are 0, and every array word reads as 0.
- R2: With wr_n high at row_go, a column write (col_go with wr_n low and fn_sel low) stores dq in full at word {row, column}, where the row is addr[ROW_W-1:0] at row_go and the column is addr[COL_W-1:0] at col_go.
- R3: With wr_n low and fn_sel low at row_go, dq at row_go becomes the plane mask for that row cycle only. Mask bit p = 1 lets plane p be written and 0 keeps the old bit. The next row cycle does not inherit this mask.
- R4: With wr_n low and fn_sel high at row_go, the stored mask gates the writes of that row cycle, and dq at row_go is ignored.
- R5: A row_go with wr_n high, such as a refresh, or a one-shot masked row_go, leaves the stored mask unchanged.
- R6: In a row opened with wr_n high and fn_sel high, a col_go with wr_n low and fn_sel low loads the stored mask from dq and changes no array word.
- R7: In such a configuration row, a col_go with wr_n low and fn_sel high loads the colour register from dq and changes no array word.
- R8: In a row opened with fn_sel low, a col_go with wr_n low and fn_sel high is a block write. The group is addr[COL_W-1:2], and dq[b] enables column 4*group+b. Each enabled column receives the colour register, and only the planes enabled by the row's plane mask are written.
- R9: No array word changes when col_go has wr_n high, when col_go arrives before any row_go since reset, or when col_go arrives in the same cycle as row_go. In the last case the row itself is still opened.
- R10: rd_data shows the word at rd_addr = {row, column} two clock edges after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_go | input | 1 | Row-strobe event, one clock wide |
| col_go | input | 1 | Column-strobe event, one clock wide |
| wr_n | input | 1 | Write enable, active low, sampled at each strobe |
| fn_sel | input | 1 | Function select, sampled at each strobe |
| addr | input | max(ROW_W,COL_W) | Row address at row_go, column address at col_go |
| dq | input | DQ_W | Data, plane mask or column enables, depending on the cycle |
| rd_addr | input | ROW_W+COL_W | Inspection address {row, column} |
| rd_data | output | DQ_W | Inspected word, registered |

## Verification
The bench targets the cases where mask sources are easy to mix up. A one-shot mask that leaked into the next row would leave plane bits unwritten. A persistent row that took its mask from dq instead of the stored value would write the wrong planes. A refresh row that reloaded the stored mask would corrupt every later persistent write. Block writes are run with partial column enables and a partial plane mask together, so a design that ORed the two masks, or that ignored either one, would write extra bits. Column strobes before any row, in the same cycle as a row strobe, or with write disabled would all show up as stray words. The bench also block-writes straight after reset, which exposes a colour register that was not cleared.

// File: rtl/vwr_pkg.sv
`timescale 1ns/1ps
package vwr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WRITE,
    OP_BLOCK,
    OP_LD_COLOR,
    OP_LD_MASK
  } col_op_e;
endpackage

// File: rtl/vwr_bit_ram.sv
`timescale 1ns/1ps
// One bit plane of one column lane; simple dual-port, registered read.
module vwr_bit_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int DEPTH = 1 << AW;

  logic mem [0:DEPTH-1];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/vwr_row_ctx.sv
`timescale 1ns/1ps
// State captured at the row strobe: row, row kind and active plane mask.
module vwr_row_ctx #(
  parameter int ROW_W = 3,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_go,
  input  logic             wr_n,
  input  logic             fn_sel,
  input  logic [ROW_W-1:0] row_in,
  input  logic [DQ_W-1:0]  dq,
  input  logic [DQ_W-1:0]  pmask_q,
  output logic [ROW_W-1:0] row_q,
  output logic             open_q,
  output logic             load_row_q,
  output logic [DQ_W-1:0]  mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q      <= '0;
      open_q     <= 1'b0;
      load_row_q <= 1'b0;
      mask_q     <= '0;
    end else if (row_go) begin
      row_q      <= row_in;
      open_q     <= 1'b1;
      load_row_q <= fn_sel & wr_n;
      if (wr_n)        mask_q <= '1;
      else if (fn_sel) mask_q <= pmask_q;
      else             mask_q <= dq;
    end
  end
endmodule

// File: rtl/vwr_cfg_regs.sv
`timescale 1ns/1ps
// Colour register and stored plane mask; each holds until its load cycle.
module vwr_cfg_regs
  import vwr_pkg::*;
#(
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  col_op_e         op,
  input  logic [DQ_W-1:0] dq,
  output logic [DQ_W-1:0] colour_q,
  output logic [DQ_W-1:0] pmask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      colour_q <= '0;
      pmask_q  <= '0;
    end else begin
      if (op == OP_LD_COLOR) colour_q <= dq;
      if (op == OP_LD_MASK)  pmask_q  <= dq;
    end
  end
endmodule

// File: rtl/vwr_lane_gate.sv
`timescale 1ns/1ps
// Decodes the column cycle and produces one enable and data bit per lane/plane.
// Vector index is lane*DQ_W + plane.
module vwr_lane_gate
  import vwr_pkg::*;
#(
  parameter int DQ_W  = 4,
  parameter int GRP_W = 2
) (
  input  logic                 col_go,
  input  logic                 row_go,
  input  logic                 open_q,
  input  logic                 load_row_q,
  input  logic                 wr_n,
  input  logic                 fn_sel,
  input  logic [GRP_W-1:0]     col_lo,
  input  logic [DQ_W-1:0]      dq,
  input  logic [DQ_W-1:0]      mask_q,
  input  logic [DQ_W-1:0]      colour_q,
  output col_op_e              op,
  output logic [DQ_W*DQ_W-1:0] we_vec,
  output logic [DQ_W*DQ_W-1:0] wbit_vec
);
  logic active;

  always_comb begin
    active = col_go && !row_go && open_q && !wr_n;
    if (!active)         op = OP_IDLE;
    else if (load_row_q) op = fn_sel ? OP_LD_COLOR : OP_LD_MASK;
    else                 op = fn_sel ? OP_BLOCK : OP_WRITE;
  end

  always_comb begin
    we_vec   = '0;
    wbit_vec = '0;
    for (int b = 0; b < DQ_W; b++) begin
      for (int p = 0; p < DQ_W; p++) begin
        case (op)
          OP_WRITE: begin
            we_vec[b*DQ_W+p]   = (col_lo == GRP_W'(b)) && mask_q[p];
            wbit_vec[b*DQ_W+p] = dq[p];
          end
          OP_BLOCK: begin
            we_vec[b*DQ_W+p]   = dq[b] && mask_q[p];
            wbit_vec[b*DQ_W+p] = colour_q[p];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vram_write_unit.sv
`timescale 1ns/1ps
module vram_write_unit
  import vwr_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 5,
  parameter int DQ_W  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int RA_W   = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_go,
  input  logic              col_go,
  input  logic              wr_n,
  input  logic              fn_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [DQ_W-1:0]   rd_data
);
  localparam int GRP_W = $clog2(DQ_W);
  localparam int BAW   = RA_W - GRP_W;
  localparam int NBIT  = DQ_W * DQ_W;

  logic [ROW_W-1:0] row_q;
  logic             open_q;
  logic             load_row_q;
  logic [DQ_W-1:0]  mask_q;
  logic [DQ_W-1:0]  colour_q;
  logic [DQ_W-1:0]  pmask_q;
  col_op_e          op;
  logic [NBIT-1:0]  we_vec;
  logic [NBIT-1:0]  wbit_vec;
  logic [NBIT-1:0]  rbit_vec;
  logic [BAW-1:0]   waddr;
  logic [GRP_W-1:0] rsel_q;
  logic [DQ_W-1:0]  rd_word;

  vwr_row_ctx #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_row (
    .clk(clk), .rst(rst), .row_go(row_go), .wr_n(wr_n), .fn_sel(fn_sel),
    .row_in(addr[ROW_W-1:0]), .dq(dq), .pmask_q(pmask_q),
    .row_q(row_q), .open_q(open_q), .load_row_q(load_row_q), .mask_q(mask_q)
  );

  vwr_cfg_regs #(.DQ_W(DQ_W)) u_cfg (
    .clk(clk), .rst(rst), .op(op), .dq(dq),
    .colour_q(colour_q), .pmask_q(pmask_q)
  );

  vwr_lane_gate #(.DQ_W(DQ_W), .GRP_W(GRP_W)) u_gate (
    .col_go(col_go), .row_go(row_go), .open_q(open_q), .load_row_q(load_row_q),
    .wr_n(wr_n), .fn_sel(fn_sel), .col_lo(addr[GRP_W-1:0]), .dq(dq),
    .mask_q(mask_q), .colour_q(colour_q),
    .op(op), .we_vec(we_vec), .wbit_vec(wbit_vec)
  );

  assign waddr = {row_q, addr[COL_W-1:GRP_W]};

  for (genvar b = 0; b < DQ_W; b++) begin : g_lane
    for (genvar p = 0; p < DQ_W; p++) begin : g_plane
      vwr_bit_ram #(.AW(BAW)) u_ram (
        .clk(clk), .we(we_vec[b*DQ_W+p]), .waddr(waddr),
        .wbit(wbit_vec[b*DQ_W+p]), .raddr(rd_addr[RA_W-1:GRP_W]),
        .rbit(rbit_vec[b*DQ_W+p])
      );
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < DQ_W; b++) begin
      if (rsel_q == GRP_W'(b)) rd_word = rbit_vec[b*DQ_W +: DQ_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= '0;
      rd_data <= '0;
    end else begin
      rsel_q  <= rd_addr[GRP_W-1:0];
      rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/vram_write_unit_chk.sv
`timescale 1ns/1ps
module vram_write_unit_chk
  import vwr_pkg::*;
#(
  parameter int DQ_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 row_go,
  input logic                 col_go,
  input logic                 wr_n,
  input col_op_e              op,
  input logic [DQ_W*DQ_W-1:0] we_vec,
  input logic [DQ_W-1:0]      mask_q,
  input logic [DQ_W-1:0]      colour_q,
  input logic [DQ_W-1:0]      pmask_q
);
  logic [DQ_W-1:0] plane_we;
  logic [DQ_W-1:0] lane_we;

  always_comb begin
    plane_we = '0;
    lane_we  = '0;
    for (int b = 0; b < DQ_W; b++) begin
      for (int p = 0; p < DQ_W; p++) begin
        plane_we[p] = plane_we[p] | we_vec[b*DQ_W+p];
        lane_we[b]  = lane_we[b]  | we_vec[b*DQ_W+p];
      end
    end
  end

  // R9: no column strobe, no array write
  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !col_go |-> (we_vec == '0));
  // R9: column strobe coinciding with a row strobe is dropped
  assert_clash_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    row_go |-> (we_vec == '0));
  // R9: read-type column strobe writes nothing
  assert_read_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (col_go && wr_n) |-> (we_vec == '0));
  // R3: a blocked plane never sees a write enable
  assert_plane_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (plane_we & ~mask_q) == '0);
  // R2: a plain column write touches one lane at most
  assert_one_lane_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WRITE) |-> $onehot0(lane_we));
  // R6, R7: configuration cycles leave the array alone
  assert_load_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LD_MASK || op == OP_LD_COLOR) |-> (we_vec == '0));
  // R5: a row strobe never alters the stored mask
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    row_go |=> $stable(pmask_q));
  // R7: colour register only moves on a column strobe
  assert_colour_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !col_go |=> $stable(colour_q));
endmodule

bind vram_write_unit vram_write_unit_chk #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst(rst), .row_go(row_go), .col_go(col_go), .wr_n(wr_n),
  .op(op), .we_vec(we_vec), .mask_q(mask_q), .colour_q(colour_q),
  .pmask_q(pmask_q)
);

// File: tb/vram_write_unit_test.sv
`timescale 1ns/1ps
module vram_write_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       row_go = 1'b0;
  logic       col_go = 1'b0;
  logic       wr_n = 1'b1;
  logic       fn_sel = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] dq = '0;
  logic [7:0] rd_addr = '0;
  logic [3:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench model, built from the requirements
  logic [3:0] exp_mem [0:255];
  bit         m_open = 1'b0;
  logic [2:0] m_row = '0;
  bit         m_load = 1'b0;
  logic [3:0] m_mask = '0;
  logic [3:0] m_pmask = '0;
  logic [3:0] m_colour = '0;

  // scoreboard
  int         q_due [$];
  int         q_addr [$];
  logic [3:0] q_exp [$];
  string      q_tag [$];

  vram_write_unit uut (
    .clk(clk), .rst(rst), .row_go(row_go), .col_go(col_go), .wr_n(wr_n),
    .fn_sel(fn_sel), .addr(addr), .dq(dq), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare when the read result is due (R10)
  always @(negedge clk) begin
    if (q_due.size() > 0 && cyc == q_due[0]) begin
      checks++;
      if (rd_data !== q_exp[0]) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", q_tag[0], q_addr[0], rd_data, q_exp[0]);
      end
      void'(q_due.pop_front());
      void'(q_addr.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit rg, input bit cg, input bit wn, input bit fs,
                      input logic [4:0] a, input logic [3:0] d);
    @(negedge clk);
    row_go = rg; col_go = cg; wr_n = wn; fn_sel = fs; addr = a; dq = d;
    if (cg && !rg && m_open && !wn) begin
      if (m_load) begin
        if (fs) m_colour = d;
        else    m_pmask  = d;
      end else if (!fs) begin
        exp_mem[{m_row, a}] = (exp_mem[{m_row, a}] & ~m_mask) | (d & m_mask);
      end else begin
        for (int b = 0; b < 4; b++) begin
          if (d[b]) begin
            logic [7:0] ix;
            ix = {m_row, a[4:2], 2'(b)};
            exp_mem[ix] = (exp_mem[ix] & ~m_mask) | (m_colour & m_mask);
          end
        end
      end
    end
    if (rg) begin
      m_open = 1'b1;
      m_row  = a[2:0];
      m_load = fs && wn;
      m_mask = wn ? 4'hF : (fs ? m_pmask : d);
    end
    @(negedge clk);
    row_go = 1'b0; col_go = 1'b0; wr_n = 1'b1; fn_sel = 1'b0;
  endtask

  task automatic row(input logic [2:0] r, input bit wn, input bit fs, input logic [3:0] d);
    step(1'b1, 1'b0, wn, fs, {2'b00, r}, d);
  endtask

  task automatic col(input logic [4:0] c, input bit wn, input bit fs, input logic [3:0] d);
    step(1'b0, 1'b1, wn, fs, c, d);
  endtask

  task automatic rd(input logic [2:0] r, input logic [4:0] c, input string tag);
    @(negedge clk);
    rd_addr = {r, c};
    q_due.push_back(cyc + 2);
    q_addr.push_back(int'({r, c}));
    q_exp.push_back(exp_mem[{r, c}]);
    q_tag.push_back(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_data !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset rd_data actual=%h expected=0", rd_data);
    end
    rd(3'd0, 5'd5, "R1 array clear");

    // R9: column strobe before any row strobe
    col(5'd3, 1'b0, 1'b0, 4'hF);
    rd(3'd0, 5'd3, "R9 col before row");

    // R2: plain writes, plus a write-disabled column cycle
    row(3'd2, 1'b1, 1'b0, 4'h0);
    col(5'd4, 1'b0, 1'b0, 4'hA);
    col(5'd5, 1'b0, 1'b0, 4'h5);
    col(5'd6, 1'b1, 1'b0, 4'hF);
    rd(3'd2, 5'd4, "R2 plain write");
    rd(3'd2, 5'd5, "R2 plain write");
    rd(3'd2, 5'd6, "R9 wr_n high at col");

    // R1/R8: block write with the reset colour clears enabled columns only
    col(5'd8, 1'b0, 1'b0, 4'hF);
    col(5'd9, 1'b0, 1'b0, 4'hF);
    col(5'd10, 1'b0, 1'b0, 4'hF);
    col(5'd9, 1'b0, 1'b1, 4'b0101);
    rd(3'd2, 5'd8, "R1 reset colour block");
    rd(3'd2, 5'd9, "R8 column enable off");
    rd(3'd2, 5'd10, "R1 reset colour block");

    // R7: load colour, array untouched
    row(3'd1, 1'b1, 1'b1, 4'h0);
    col(5'd0, 1'b0, 1'b1, 4'h6);
    rd(3'd1, 5'd0, "R7 colour load no write");
    // R6: load stored mask, array untouched
    row(3'd1, 1'b1, 1'b1, 4'h0);
    col(5'd0, 1'b0, 1'b0, 4'hA);
    rd(3'd1, 5'd0, "R6 mask load no write");

    // R3: one-shot mask, then not inherited
    row(3'd3, 1'b0, 1'b0, 4'h3);
    col(5'd0, 1'b0, 1'b0, 4'hF);
    col(5'd1, 1'b0, 1'b0, 4'hC);
    rd(3'd3, 5'd0, "R3 one-shot mask");
    rd(3'd3, 5'd1, "R3 one-shot all planes blocked");
    row(3'd3, 1'b1, 1'b0, 4'h0);
    col(5'd1, 1'b0, 1'b0, 4'hC);
    rd(3'd3, 5'd1, "R3 mask not inherited");

    // R4: persistent mask, dq at row ignored
    row(3'd4, 1'b0, 1'b1, 4'h5);
    col(5'd2, 1'b0, 1'b0, 4'hF);
    rd(3'd4, 5'd2, "R4 persistent mask");

    // R5: refresh rows and a one-shot row keep the stored mask
    row(3'd5, 1'b1, 1'b0, 4'h0);
    row(3'd6, 1'b1, 1'b0, 4'h3);
    row(3'd6, 1'b0, 1'b0, 4'h1);
    row(3'd4, 1'b0, 1'b1, 4'hF);
    col(5'd3, 1'b0, 1'b0, 4'hF);
    rd(3'd4, 5'd3, "R5 stored mask kept");

    // R8: block write with column enables ANDed with plane mask
    row(3'd6, 1'b1, 1'b0, 4'h0);
    for (int c = 12; c < 16; c++) col(5'(c), 1'b0, 1'b0, 4'h3);
    row(3'd6, 1'b0, 1'b0, 4'hC);
    col(5'd13, 1'b0, 1'b1, 4'b1011);
    for (int c = 12; c < 16; c++) rd(3'd6, 5'(c), "R8 masked block write");

    // R9: column strobe in the same cycle as row strobe; row still opened
    step(1'b1, 1'b1, 1'b0, 1'b0, 5'd7, 4'hF);
    rd(3'd7, 5'd7, "R9 clash ignored new row");
    rd(3'd6, 5'd7, "R9 clash ignored old row");
    col(5'd1, 1'b0, 1'b0, 4'h9);
    rd(3'd7, 5'd1, "R9 row opened on clash");

    // R4/R8: reload stored mask, persistent block write
    row(3'd1, 1'b1, 1'b1, 4'h0);
    col(5'd0, 1'b0, 1'b0, 4'h6);
    row(3'd0, 1'b0, 1'b1, 4'h0);
    col(5'd16, 1'b0, 1'b1, 4'hF);
    for (int c = 16; c < 20; c++) rd(3'd0, 5'(c), "R4 R8 persistent block");
    rd(3'd0, 5'd20, "R8 outside group");

    while (q_due.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule